// File: doc/BRIEF.md
# Chip-Select Gated Dual-Copy Command Register

This block registers the command and address bits heading for the memory devices on a module. Every bit is driven out twice, as copy A and copy B, so each copy can serve its own half of the load. The block has 28 input bit positions. A static configuration select decides which of them carry gated data. The others carry the two clock-enable bits, the two termination-control bits and chip selects 0 and 1. Chip selects 2 and 3 arrive on their own pins. They take part in gating but are not driven out.

When the gating enable is HIGH, a rising edge loads the data positions only if at least one of the four active-low chip selects is LOW. If none is LOW, the data outputs keep their value, which saves switching power while no device is addressed. Clock-enable, termination and the two re-driven chip selects load on every edge whatever the gating state. When the gating enable is LOW, every position loads on every edge. An asynchronous active-low reset clears every register, so all output copies go LOW at once.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: While rst_n is LOW, every bit of q_a and q_b is 0. The clear takes effect without waiting for a clock edge and overrides all gating.
- R2: q_a and q_b are bit-identical in every cycle.
- R3: With gate_en LOW, every data position of the outputs takes the value that cmd_in held at the previous rising edge, whatever the chip selects are.
- R4: With gate_en HIGH, the data positions load at a rising edge when at least one chip select is LOW at that edge. Any one of the four is enough, including cs_ext_n[0] (chip select 2) and cs_ext_n[1] (chip select 3).
- R5: With gate_en HIGH and all four chip selects HIGH at a rising edge, the data positions of both copies keep their previous value. Changes on the data inputs have no effect.
- R6: The clock-enable and termination positions load at every rising edge, whatever the states of gate_en and the chip selects.
- R7: The chip select 0 and chip select 1 positions are registered at every rising edge and appear on both copies.
- R8: With cfg_sel = 0, the data positions (numbered 1 to 28, bit index = position - 1) are 1-5, 7, 9-12 and 17-28. Position 6 is clock-enable 1, 8 is clock-enable 0, 13 is chip select 1, 14 is chip select 0, 15 is termination 0 and 16 is termination 1.
- R9: With cfg_sel = 1, the data positions are 1-12, 17-20, 22 and 24-28. Position 13 is termination 1, 14 is termination 0, 15 is chip select 0, 16 is chip select 1, 21 is clock-enable 0 and 23 is clock-enable 1.
- R10: cfg_sel is static. It may change only while rst_n is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| cfg_sel | input | 1 | Static position-map select |
| gate_en | input | 1 | HIGH enables chip-select gating of data positions |
| cmd_in | input | 28 | Input positions; bit i is position i+1 |
| cs_ext_n | input | 2 | Chip selects 2 and 3, active low, not re-driven |
| q_a | output | 28 | Output copy A, same position map as cmd_in |
| q_b | output | 28 | Output copy B, same position map as cmd_in |

## Verification
The bench sweeps all sixteen chip-select combinations under both gating states and both maps. A design that gated on only two chip selects would wrongly freeze data when only chip select 2 or 3 is LOW. A long run with every chip select HIGH checks two failure modes: gated data that leaks through, and clock-enable or termination bits that freeze along with the data. Reset is dropped between clock edges, so a design with a synchronous clear is caught. The bench's own position map is compared against the design in both configurations, which catches a swapped role.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

   localparam int unsigned POS_W  = 28;
   localparam int unsigned DATA_W = 22;
   localparam int unsigned CS_W   = 4;

   typedef enum logic [2:0] {
      ROLE_DATA = 3'd0,
      ROLE_CKE0 = 3'd1,
      ROLE_CKE1 = 3'd2,
      ROLE_ODT0 = 3'd3,
      ROLE_ODT1 = 3'd4,
      ROLE_CS0  = 3'd5,
      ROLE_CS1  = 3'd6
   } role_e;

   // role of 1-based position p under map cfg
   function automatic role_e pos_role(input logic cfg, input int p);
      role_e r;
      r = ROLE_DATA;
      if (!cfg) begin
         case (p)
            6:       r = ROLE_CKE1;
            8:       r = ROLE_CKE0;
            13:      r = ROLE_CS1;
            14:      r = ROLE_CS0;
            15:      r = ROLE_ODT0;
            16:      r = ROLE_ODT1;
            default: r = ROLE_DATA;
         endcase
      end else begin
         case (p)
            13:      r = ROLE_ODT1;
            14:      r = ROLE_ODT0;
            15:      r = ROLE_CS0;
            16:      r = ROLE_CS1;
            21:      r = ROLE_CKE0;
            23:      r = ROLE_CKE1;
            default: r = ROLE_DATA;
         endcase
      end
      return r;
   endfunction

   function automatic logic [POS_W-1:0] data_mask(input logic cfg);
      logic [POS_W-1:0] m;
      for (int i = 0; i < int'(POS_W); i++)
         m[i] = (pos_role(cfg, i + 1) == ROLE_DATA);
      return m;
   endfunction

   function automatic int count_data(input logic cfg);
      int n;
      n = 0;
      for (int i = 0; i < int'(POS_W); i++)
         if (pos_role(cfg, i + 1) == ROLE_DATA) n++;
      return n;
   endfunction

endpackage

// File: rtl/cgr_pos_map.sv
module cgr_pos_map
   import cgr_pkg::*;
#(
   parameter int unsigned W = POS_W
) (
   input  logic         cfg_sel,
   input  logic [W-1:0] cmd_in,
   output logic [W-1:0] data_mask,
   output logic [1:0]   cs_pos_n
);

   logic [W-1:0] is_cs0;
   logic [W-1:0] is_cs1;

   for (genvar i = 0; i < int'(W); i++) begin : g_pos
      localparam role_e ROLE_M0 = pos_role(1'b0, i + 1);
      localparam role_e ROLE_M1 = pos_role(1'b1, i + 1);
      assign data_mask[i] = cfg_sel ? (ROLE_M1 == ROLE_DATA) : (ROLE_M0 == ROLE_DATA);
      assign is_cs0[i]    = cfg_sel ? (ROLE_M1 == ROLE_CS0)  : (ROLE_M0 == ROLE_CS0);
      assign is_cs1[i]    = cfg_sel ? (ROLE_M1 == ROLE_CS1)  : (ROLE_M0 == ROLE_CS1);
   end

   // a one-hot select picks the chip-select bit; a missing one reads as inactive
   assign cs_pos_n[0] = |(cmd_in & is_cs0) | ~|is_cs0;
   assign cs_pos_n[1] = |(cmd_in & is_cs1) | ~|is_cs1;

endmodule

// File: rtl/cgr_gate_ctrl.sv
module cgr_gate_ctrl #(
   parameter int unsigned NCS = 4
) (
   input  logic           gate_en,
   input  logic [NCS-1:0] cs_n,
   output logic           capture
);

   logic any_sel;

   assign any_sel = ~&cs_n;
   assign capture = ~gate_en | any_sel;

endmodule

// File: rtl/cgr_reg_bank.sv
module cgr_reg_bank #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic [W-1:0] ld_en,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < int'(W); i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= 1'b0;
         else if (ld_en[i])
            q[i] <= d[i];
      end
   end

endmodule

// File: rtl/cgr_fanout.sv
module cgr_fanout #(
   parameter int unsigned W      = 28,
   parameter int unsigned COPIES = 2
) (
   input  logic [W-1:0]             src,
   output logic [COPIES-1:0][W-1:0] dst
);

   for (genvar c = 0; c < int'(COPIES); c++) begin : g_copy
      assign dst[c] = src;
   end

endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg
   import cgr_pkg::*;
#(
   parameter int unsigned N_POS    = POS_W,
   parameter int unsigned N_EXT_CS = CS_W - 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_sel,
   input  logic                gate_en,
   input  logic [N_POS-1:0]    cmd_in,
   input  logic [N_EXT_CS-1:0] cs_ext_n,
   output logic [N_POS-1:0]    q_a,
   output logic [N_POS-1:0]    q_b
);

   localparam int unsigned N_CS   = N_EXT_CS + 2;
   localparam int unsigned COPIES = 2;

   if (N_POS != POS_W) begin : g_bad_pos
      $error("cs_gated_cmd_reg: N_POS must equal the fixed position map width");
   end
   if (count_data(1'b0) != int'(DATA_W) || count_data(1'b1) != int'(DATA_W)) begin : g_bad_map
      $error("cs_gated_cmd_reg: position map does not yield the expected data width");
   end

   logic [N_POS-1:0]             data_mask;
   logic [1:0]                   cs_pos_n;
   logic                         capture;
   logic [N_POS-1:0]             ld_en;
   logic [N_POS-1:0]             q_reg;
   logic [COPIES-1:0][N_POS-1:0] q_copy;

   cgr_pos_map #(.W(N_POS)) u_map (
      .cfg_sel   (cfg_sel),
      .cmd_in    (cmd_in),
      .data_mask (data_mask),
      .cs_pos_n  (cs_pos_n)
   );

   cgr_gate_ctrl #(.NCS(N_CS)) u_gate (
      .gate_en (gate_en),
      .cs_n    ({cs_ext_n, cs_pos_n}),
      .capture (capture)
   );

   assign ld_en = ~data_mask | {N_POS{capture}};

   cgr_reg_bank #(.W(N_POS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmd_in),
      .ld_en (ld_en),
      .q     (q_reg)
   );

   cgr_fanout #(.W(N_POS), .COPIES(COPIES)) u_fan (
      .src (q_reg),
      .dst (q_copy)
   );

   assign q_a = q_copy[0];
   assign q_b = q_copy[1];

endmodule

// File: rtl/cgr_checker.sv
module cgr_checker
   import cgr_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_sel,
   input logic             gate_en,
   input logic [POS_W-1:0] cmd_in,
   input logic [1:0]       cs_ext_n,
   input logic [POS_W-1:0] q_a,
   input logic [POS_W-1:0] q_b
);

   logic [POS_W-1:0] dm;
   logic             cs0_n, cs1_n, all_idle;

   assign dm       = data_mask(cfg_sel);
   assign cs0_n    = cfg_sel ? cmd_in[14] : cmd_in[13];
   assign cs1_n    = cfg_sel ? cmd_in[15] : cmd_in[12];
   assign all_idle = cs0_n & cs1_n & cs_ext_n[0] & cs_ext_n[1];

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (q_a == '0 && q_b == '0));

   assert_copies_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      q_a == q_b);

   assert_ungated_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |=> ((q_a & dm) == ($past(cmd_in) & dm)));

   assert_selected_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && !all_idle) |=> ((q_a & dm) == ($past(cmd_in) & dm)));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && all_idle) |=> ((q_a & dm) == ($past(q_a) & dm)));

   // R6 and R7: control and chip-select positions load every edge
   assert_ctrl_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_a & ~dm) == ($past(cmd_in) & ~dm)));

   assert_cfg_static_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(cfg_sel));

endmodule

bind cs_gated_cmd_reg cgr_checker u_chk (.*);

// File: tb/tb_cs_gated_cmd_reg.sv
module tb_cs_gated_cmd_reg;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_sel;
   logic        gate_en;
   logic [27:0] cmd_in;
   logic [1:0]  cs_ext_n;
   logic [27:0] q_a, q_b;

   int n_cmp = 0;
   int n_bad = 0;
   logic [27:0] exp_q;
   logic [31:0] lfsr = 32'h1ACE_B00C;
   logic        done = 1'b0;

   always #4 clk = ~clk;

   cs_gated_cmd_reg dut (
      .clk (clk), .rst_n (rst_n), .cfg_sel (cfg_sel), .gate_en (gate_en),
      .cmd_in (cmd_in), .cs_ext_n (cs_ext_n), .q_a (q_a), .q_b (q_b)
   );

   // R8 and R9 maps written from the requirement text
   function automatic logic is_data(input logic c, input int p);
      if (!c) return (p <= 5) || (p == 7) || (p >= 9 && p <= 12) || (p >= 17);
      else    return (p <= 12) || (p >= 17 && p <= 20) || (p == 22) || (p >= 24);
   endfunction

   function automatic logic [27:0] mask_of(input logic c);
      logic [27:0] m;
      for (int p = 1; p <= 28; p++) m[p-1] = is_data(c, p);
      return m;
   endfunction

   function automatic int cs0_pos(input logic c); return c ? 15 : 14; endfunction
   function automatic int cs1_pos(input logic c); return c ? 16 : 13; endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic check(input string tag, input logic [27:0] act, input logic [27:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic step(input logic [27:0] v, input logic [1:0] ext, input logic g);
      logic        cap;
      logic [27:0] m;
      string       td;
      cmd_in   = v;
      cs_ext_n = ext;
      gate_en  = g;
      @(posedge clk);
      cap = !g || !(v[cs0_pos(cfg_sel)-1] & v[cs1_pos(cfg_sel)-1] & ext[0] & ext[1]);
      for (int p = 1; p <= 28; p++)
         if (!is_data(cfg_sel, p) || cap) exp_q[p-1] = v[p-1];
      @(negedge clk);
      m  = mask_of(cfg_sel);
      td = $sformatf("%s %s data", !g ? "R3" : (cap ? "R4" : "R5"), cfg_sel ? "R9" : "R8");
      check(td, q_a & m, exp_q & m);
      check($sformatf("R6 R7 %s ctrl", cfg_sel ? "R9" : "R8"), q_a & ~m, exp_q & ~m);
      check("R2 copy", q_b, q_a);
   endtask

   task automatic do_reset(input logic c);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async clear A", q_a, '0);
      check("R1 async clear B", q_b, '0);
      @(negedge clk);
      cfg_sel = c;
      cmd_in  = '0;
      @(negedge clk);
      @(negedge clk);
      check("R1 held clear", q_a, '0);
      rst_n = 1'b1;
      exp_q = '0;
   endtask

   initial begin
      rst_n    = 1'b0;
      cfg_sel  = 1'b0;
      gate_en  = 1'b0;
      cmd_in   = '0;
      cs_ext_n = 2'b11;
      exp_q    = '0;
      repeat (3) @(negedge clk);
      check("R1 reset A", q_a, '0);
      check("R1 reset B", q_b, '0);
      rst_n = 1'b1;

      for (int c = 0; c < 2; c++) begin
         do_reset(c[0]);
         // sweep gating state x all chip-select combinations x data patterns
         for (int g = 0; g < 2; g++)
            for (int cs = 0; cs < 16; cs++)
               for (int k = 0; k < 6; k++) begin
                  logic [27:0] v;
                  lfsr = next_rand(lfsr);
                  v = lfsr[27:0];
                  v[cs0_pos(cfg_sel)-1] = cs[0];
                  v[cs1_pos(cfg_sel)-1] = cs[1];
                  step(v, cs[3:2], g[0]);
               end
         // long idle hold: data frozen, controls keep tracking (R5, R6)
         for (int k = 0; k < 60; k++) begin
            logic [27:0] v;
            lfsr = next_rand(lfsr);
            v = lfsr[27:0];
            v[cs0_pos(cfg_sel)-1] = 1'b1;
            v[cs1_pos(cfg_sel)-1] = 1'b1;
            step(v, 2'b11, 1'b1);
         end
         // a single late select reopens capture
         begin
            logic [27:0] v;
            lfsr = next_rand(lfsr);
            v = lfsr[27:0];
            v[cs0_pos(cfg_sel)-1] = 1'b1;
            v[cs1_pos(cfg_sel)-1] = 1'b1;
            step(v, 2'b01, 1'b1);
         end
      end
      do_reset(1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule